// File: doc/BRIEF.md
# Packed Lane Add/Subtract Unit

This unit adds or subtracts two operand vectors, treating each as a row of equal-width integer elements. Element width, signedness and operation are chosen per transfer. Every element position computes on its own, with no carry or borrow passing between neighbours. The result can wrap, saturate, halve or round-then-halve. Three shape variants change how lanes are sized. The long shape widens both half-width sources. The wide shape widens only the second source. The narrow shape computes on double-width lanes and returns the upper half of each lane.

Operands enter on a valid/ready stream and the result leaves on a second valid/ready stream after one register stage. A transfer is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high when the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the result is held unchanged and no new operands are taken.

A sticky saturation indicator gathers clamp events from saturating transfers. It stays set until software pulses the clear pin.

Top module: `simd_addsub`

## Requirements
- R1: Field encodings are: `esize` 0/1/2/3 selects 8/16/32/64-bit elements; `mode` 0 wraps, 1 saturates, 2 halves, 3 rounds then halves; `shape` 0 is same-width, 1 long, 2 wide, 3 narrow; `is_sub` 1 subtracts b from a. Lane k occupies bits starting at k times the lane width, and in wrap mode each lane returns its sum or difference modulo 2^width, with no effect on other lanes.
- R2: With shape 0 and `quad` low, only the low 64 bits of a and b are used, bits 127:64 of the result are zero, and upper lanes never raise the saturation indicator.
- R3: In saturating mode, an unsigned lane clamps to 0 or all-ones, and a signed lane clamps to the most negative or most positive value of its width.
- R4: Halving mode returns the exact sum or difference, taken one bit wider than the lane so no carry is lost, then shifted right by one with the fraction truncated toward minus infinity.
- R5: Rounding-halving mode adds one to the exact result before the right shift, so a dropped half rounds upward.
- R6: The long shape (esize 0 to 2 only) sign- or zero-extends each element of the low 64 bits of both a and b to double width and computes on 128 bits of double-width lanes.
- R7: The wide shape (esize 0 to 2 only) takes a as 128 bits of double-width lanes and extends only the low 64 bits of b.
- R8: The narrow shape (esize 0 to 2 only) computes a and b as double-width lanes under the chosen mode. It then packs the upper half of each lane result into bits 63:0 and leaves bits 127:64 zero.
- R9: The saturation indicator is set when an accepted saturating transfer clamps any active lane. It stays set through later transfers until cleared.
- R10: A high `sat_clr` clears the indicator on the next edge, and it overrides a saturation event accepted in the same cycle.
- R11: An accepted transfer's result appears with `out_valid` on the next cycle. A stalled result stays stable, and `in_ready` is low while a result is stalled.
- R12: After reset `out_valid` and `sat_flag` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand transfer offered |
| in_ready | output | 1 | Unit can take operands |
| a | input | VEC_W | First operand vector |
| b | input | VEC_W | Second operand vector |
| esize | input | 2 | Element size code |
| is_signed | input | 1 | Elements are signed |
| is_sub | input | 1 | Subtract instead of add |
| mode | input | 2 | Result modifier |
| shape | input | 2 | Lane shape |
| quad | input | 1 | 128-bit vector for shape 0 |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes result |
| result | output | VEC_W | Result vector |
| sat_clr | input | 1 | Clear saturation indicator |
| sat_flag | output | 1 | Sticky saturation indicator |

## Verification
The assertions assume that no long, wide or narrow transfer asks for 64-bit elements. This is the one element size with no double-width lane, and a checker property flags it at the input. The stimulus draws the element size from 8, 16 and 32 bits whenever the shape is not same-width. Clears are issued only once the output stream is empty, or with the consumer held ready, so the indicator seen with each result is the value left by that result's own transfer.

// File: rtl/simd_addsub_pkg.sv
package simd_addsub_pkg;
  typedef enum logic [1:0] {MD_WRAP, MD_SAT, MD_HALF, MD_RHALF} mode_e;
  typedef enum logic [1:0] {SH_SAME, SH_LONG, SH_WIDE, SH_NARROW} shape_e;
  localparam int BASE_W = 8;
  localparam int NUM_SZ = 4;
endpackage

// File: rtl/simd_lane.sv
module simd_lane
  import simd_addsub_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sgn_i,
  input  logic         sub_i,
  input  logic [1:0]   mode_i,
  output logic [W-1:0] r_o,
  output logic         sat_o
);
  localparam int XW = W + 2;

  logic [XW-1:0] ax, bx, s;

  always_comb begin
    ax    = {{2{sgn_i & a_i[W-1]}}, a_i};
    bx    = {{2{sgn_i & b_i[W-1]}}, b_i};
    s     = sub_i ? (ax - bx) : (ax + bx);
    r_o   = s[W-1:0];
    sat_o = 1'b0;
    case (mode_e'(mode_i))
      MD_SAT: begin
        if (sgn_i) begin
          if (s[XW-1:W-1] != {3{s[XW-1]}}) begin
            sat_o = 1'b1;
            r_o   = s[XW-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
          end
        end else if (s[XW-1]) begin
          sat_o = 1'b1;
          r_o   = '0;
        end else if (s[W]) begin
          sat_o = 1'b1;
          r_o   = '1;
        end
      end
      MD_HALF:  r_o = s[W:1];
      MD_RHALF: r_o = s[W:1] + W'(s[0]);
      default:  r_o = s[W-1:0];
    endcase
  end
endmodule

// File: rtl/simd_lane_bank.sv
module simd_lane_bank #(
  parameter int VEC_W = 128,
  parameter int W     = 8,
  localparam int NL   = VEC_W / W
) (
  input  logic [VEC_W-1:0] a_i,
  input  logic [VEC_W-1:0] b_i,
  input  logic             sgn_i,
  input  logic             sub_i,
  input  logic [1:0]       mode_i,
  output logic [VEC_W-1:0] r_o,
  output logic [NL-1:0]    sat_o
);
  for (genvar l = 0; l < NL; l++) begin : g_lane
    simd_lane #(.W(W)) u_lane (
      .a_i   (a_i[l*W +: W]),
      .b_i   (b_i[l*W +: W]),
      .sgn_i (sgn_i),
      .sub_i (sub_i),
      .mode_i(mode_i),
      .r_o   (r_o[l*W +: W]),
      .sat_o (sat_o[l])
    );
  end
endmodule

// File: rtl/simd_addsub.sv
module simd_addsub
  import simd_addsub_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [VEC_W-1:0] a,
  input  logic [VEC_W-1:0] b,
  input  logic [1:0]       esize,
  input  logic             is_signed,
  input  logic             is_sub,
  input  logic [1:0]       mode,
  input  logic [1:0]       shape,
  input  logic             quad,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VEC_W-1:0] result,
  input  logic             sat_clr,
  output logic             sat_flag
);
  localparam int HALF_W = VEC_W / 2;
  localparam int NPROM  = NUM_SZ - 1;

  logic [NPROM-1:0][VEC_W-1:0]  prom_a, prom_b;
  logic [NPROM-1:0][HALF_W-1:0] narrow_g;
  logic [NUM_SZ-1:0][VEC_W-1:0] bank_r;
  logic [NUM_SZ-1:0]            bank_sat;
  logic [VEC_W-1:0]             op_a, op_b, wide_r, next_res;
  logic [1:0]                   sel, opw;
  logic                         half_only, sat_hit, accept;
  shape_e                       shp;

  assign shp       = shape_e'(shape);
  assign sel       = (esize == 2'd3) ? 2'd2 : esize;
  assign opw       = (shp == SH_SAME) ? esize : sel + 2'd1;
  assign half_only = (shp == SH_SAME) && !quad;

  // Promotion of the low half of each source to double-width lanes
  for (genvar g = 0; g < NPROM; g++) begin : g_prom
    localparam int NW = BASE_W << g;
    for (genvar l = 0; l < HALF_W / NW; l++) begin : g_el
      assign prom_a[g][2*NW*l +: 2*NW] = {{NW{is_signed & a[NW*l+NW-1]}}, a[NW*l +: NW]};
      assign prom_b[g][2*NW*l +: 2*NW] = {{NW{is_signed & b[NW*l+NW-1]}}, b[NW*l +: NW]};
    end
  end

  always_comb begin
    op_a = (shp == SH_LONG) ? prom_a[sel] : a;
    op_b = (shp == SH_LONG || shp == SH_WIDE) ? prom_b[sel] : b;
  end

  // One lane bank per lane width; the active one is chosen by opw
  for (genvar g = 0; g < NUM_SZ; g++) begin : g_bank
    localparam int W      = BASE_W << g;
    localparam int NL     = VEC_W / W;
    localparam int NL_LOW = HALF_W / W;
    logic [NL-1:0] lane_sat;

    simd_lane_bank #(.VEC_W(VEC_W), .W(W)) u_bank (
      .a_i   (op_a),
      .b_i   (op_b),
      .sgn_i (is_signed),
      .sub_i (is_sub),
      .mode_i(mode),
      .r_o   (bank_r[g]),
      .sat_o (lane_sat)
    );

    assign bank_sat[g] = half_only ? (|lane_sat[NL_LOW-1:0]) : (|lane_sat);
  end

  // Narrowing keeps the upper half of each double-width lane
  for (genvar g = 0; g < NPROM; g++) begin : g_narrow
    localparam int NW = BASE_W << g;
    for (genvar l = 0; l < HALF_W / NW; l++) begin : g_el
      assign narrow_g[g][NW*l +: NW] = bank_r[g+1][2*NW*l + NW +: NW];
    end
  end

  always_comb begin
    wide_r  = bank_r[opw];
    sat_hit = bank_sat[opw] && (mode_e'(mode) == MD_SAT);
    case (shp)
      SH_SAME:   next_res = quad ? wide_r : {{HALF_W{1'b0}}, wide_r[HALF_W-1:0]};
      SH_NARROW: next_res = {{HALF_W{1'b0}}, narrow_g[sel]};
      default:   next_res = wide_r;
    endcase
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      sat_flag  <= 1'b0;
    end else begin
      if (accept) begin
        out_valid <= 1'b1;
        result    <= next_res;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
      if (sat_clr)
        sat_flag <= 1'b0;
      else if (accept && sat_hit)
        sat_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/simd_addsub_chk.sv
module simd_addsub_chk #(
  parameter int VEC_W = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [1:0]       esize,
  input logic [1:0]       mode,
  input logic [1:0]       shape,
  input logic             quad,
  input logic             out_valid,
  input logic             out_ready,
  input logic [VEC_W-1:0] result,
  input logic             sat_clr,
  input logic             sat_flag
);
  localparam int HALF_W = VEC_W / 2;

  // R6
  shape_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (shape != 2'd0) |-> (esize != 2'd3));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(result));

  // R11
  stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R11
  accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R2
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && ((shape == 2'd3) || ((shape == 2'd0) && !quad))
    |=> (result[VEC_W-1:HALF_W] == '0));

  // R10
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sat_clr |=> !sat_flag);

  // R9
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sat_flag && !sat_clr |=> sat_flag);

  // R9
  set_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sat_flag) |-> $past(in_valid && in_ready && (mode == 2'd1)));
endmodule

bind simd_addsub simd_addsub_chk #(.VEC_W(VEC_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .esize    (esize),
  .mode     (mode),
  .shape    (shape),
  .quad     (quad),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .result   (result),
  .sat_clr  (sat_clr),
  .sat_flag (sat_flag)
);

// File: tb/simd_addsub_bench.sv
module simd_addsub_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] a = '0, b = '0;
  logic [1:0]   esize = '0, mode = '0, shape = '0;
  logic         is_signed = 1'b0, is_sub = 1'b0, quad = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] result;
  logic         sat_clr = 1'b0;
  logic         sat_flag;

  int checks = 0;
  int errors = 0;
  bit force_rdy = 1'b1;
  bit flag_m = 1'b0;
  bit done = 1'b0;

  logic [127:0] exp_r[$];
  bit           exp_f[$];
  string        exp_t[$];

  simd_addsub #(.VEC_W(128)) u_simd_addsub (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .a(a), .b(b), .esize(esize), .is_signed(is_signed), .is_sub(is_sub),
    .mode(mode), .shape(shape), .quad(quad), .out_valid(out_valid),
    .out_ready(out_ready), .result(result), .sat_clr(sat_clr), .sat_flag(sat_flag)
  );

  always #4 clk = ~clk;

  task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] mask(int w);
    return (128'd1 << w) - 128'd1;
  endfunction

  function automatic logic signed [69:0] lane(logic [127:0] v, int i, int w, bit sg);
    logic [127:0] e;
    logic signed [69:0] t;
    e = (v >> (i * w)) & mask(w);
    t = $signed({6'b0, e[63:0]});
    if (sg && e[w-1]) t = t - (70'sd1 <<< w);
    return t;
  endfunction

  function automatic void model(logic [127:0] av, bv, int esz, bit sg, bit sb,
                                int md, int sh, bit q,
                                output logic [127:0] r, output bit sat);
    int nw = 8 << esz;
    int ow = (sh == 0) ? nw : 2 * nw;
    int act = (sh == 0 && !q) ? 64 : 128;
    logic [127:0] aa, bb;
    aa = av; bb = bv; r = '0; sat = 1'b0;
    if (sh == 1 || sh == 2) begin
      bb = '0;
      for (int i = 0; i < 64 / nw; i++)
        bb |= (128'(lane(bv, i, nw, sg)) & mask(ow)) << (i * ow);
    end
    if (sh == 1) begin
      aa = '0;
      for (int i = 0; i < 64 / nw; i++)
        aa |= (128'(lane(av, i, nw, sg)) & mask(ow)) << (i * ow);
    end
    for (int i = 0; i < act / ow; i++) begin
      logic signed [69:0] x, y, s, lo, hi, v;
      logic [127:0] vb;
      x = lane(aa, i, ow, sg);
      y = lane(bb, i, ow, sg);
      s = sb ? x - y : x + y;
      if (sg) begin
        hi = (70'sd1 <<< (ow - 1)) - 70'sd1;
        lo = -(70'sd1 <<< (ow - 1));
      end else begin
        hi = (70'sd1 <<< ow) - 70'sd1;
        lo = 70'sd0;
      end
      case (md)
        1: if (s > hi) begin v = hi; sat = 1'b1; end
           else if (s < lo) begin v = lo; sat = 1'b1; end
           else v = s;
        2: v = s >>> 1;
        3: v = (s + 70'sd1) >>> 1;
        default: v = s;
      endcase
      vb = 128'(v) & mask(ow);
      if (sh == 3) r |= ((vb >> (ow / 2)) & mask(ow / 2)) << (i * ow / 2);
      else         r |= vb << (i * ow);
    end
  endfunction

  task automatic send(string tag, logic [127:0] av, bv, int esz, bit sg, bit sb,
                      int md, int sh, bit q, bit clr);
    logic [127:0] r;
    bit sat;
    model(av, bv, esz, sg, sb, md, sh, q, r, sat);
    flag_m = clr ? 1'b0 : (flag_m | sat);
    exp_r.push_back(r); exp_f.push_back(flag_m); exp_t.push_back(tag);
    @(negedge clk);
    a = av; b = bv; esize = 2'(esz); is_signed = sg; is_sub = sb;
    mode = 2'(md); shape = 2'(sh); quad = q; sat_clr = clr; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    sat_clr = 1'b0;
  endtask

  task automatic drain();
    while (exp_r.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Consumer back-pressure, changed away from both clock edges
  initial begin
    forever begin
      @(posedge clk);
      #2;
      out_ready = force_rdy ? 1'b1 : ($urandom % 4 != 0);
    end
  end

  // Scoreboard monitor
  logic [127:0] held = '0;
  bit stalled = 1'b0;
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (out_ready) begin
        stalled <= 1'b0;
        if (exp_r.size() == 0) begin
          check(1'b0, "R11 unexpected result", result, '0);
        end else begin
          logic [127:0] er;
          bit ef;
          string et;
          er = exp_r.pop_front(); ef = exp_f.pop_front(); et = exp_t.pop_front();
          check(result == er, et, result, er);
          check(sat_flag == ef, {et, " R9 flag"}, 128'(sat_flag), 128'(ef));
        end
      end else begin
        if (stalled) check(result == held, "R11 stall hold", result, held);
        held <= result;
        stalled <= 1'b1;
      end
    end else begin
      stalled <= 1'b0;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R12
    check(!out_valid, "R12 out_valid", 128'(out_valid), 128'd0);
    check(!sat_flag, "R12 sat_flag", 128'(sat_flag), 128'd0);
    check(in_ready, "R12 in_ready", 128'(in_ready), 128'd1);

    // R1 lane independence: a carry out of lane 0 must not reach lane 1
    send("R1 u16 wrap", 128'h0000_0000_0000_0000_1111_2222_3333_FFFF,
         128'h0000_0000_0000_0000_0001_0001_0001_0001, 1, 0, 0, 0, 0, 1, 0);
    send("R1 s32 sub", 128'h8000_0000_0000_0001_7FFF_FFFF_0000_0000,
         128'h0000_0001_0000_0002_FFFF_FFFF_0000_0001, 2, 1, 1, 0, 0, 1, 0);
    // R2 upper input halves ignored for 64-bit vectors
    send("R2 half vector", 128'hDEAD_BEEF_DEAD_BEEF_0102_0304_0506_0708,
         128'hFFFF_FFFF_FFFF_FFFF_1010_1010_1010_1010, 0, 0, 0, 1, 0, 0, 0);
    drain();
    check(!sat_flag, "R2 upper lanes do not saturate", 128'(sat_flag), 128'd0);
    // R3 clamps
    send("R3 s8 max", 128'h7F, 128'h01, 0, 1, 0, 1, 0, 0, 0);
    send("R3 u8 zero", 128'h00, 128'h01, 0, 0, 1, 1, 0, 0, 0);
    send("R3 s16 min", 128'h8000, 128'h0001, 1, 1, 1, 1, 0, 1, 0);
    send("R3 u64 ones", 128'hFFFF_FFFF_FFFF_FFF0, 128'h20, 3, 0, 0, 1, 0, 1, 0);
    // R4 / R5 halving keeps the carry
    send("R4 u8 halve", 128'hFF, 128'hFF, 0, 0, 0, 2, 0, 0, 0);
    send("R4 s16 halve", 128'hFFFD, 128'h0000, 1, 1, 0, 2, 0, 0, 0);
    send("R5 u8 round", 128'hFF, 128'h00, 0, 0, 0, 3, 0, 0, 0);
    send("R5 s32 round", 128'hFFFF_FFFD, 128'h0, 2, 1, 0, 3, 0, 1, 0);
    // R6 / R7 / R8 shapes
    send("R6 long s8", 128'h80FF_7F01_0203_0405, 128'hFF01_7F80_0102_0304, 0, 1, 0, 0, 1, 0, 0);
    send("R6 long u32", 128'hFFFF_FFFF_0000_0001, 128'hFFFF_FFFF_FFFF_FFFF, 2, 0, 0, 0, 1, 0, 0);
    send("R7 wide u16", 128'h0001_0000_0002_0000_0003_0000_FFFF_FFFF,
         128'h0000_0000_0000_0000_FFFF_0001_8000_0001, 1, 0, 0, 0, 2, 0, 0);
    send("R7 wide s8 sub", {8{16'h00FF}}, 128'h0000_0000_0000_0000_8001_7FFE_0102_0304,
         0, 1, 1, 0, 2, 0, 0);
    send("R8 narrow u16", {4{32'h1234_8000}}, {4{32'h0001_8000}}, 1, 0, 0, 0, 3, 0, 0);
    send("R8 narrow s8 sat", {8{16'h7FFF}}, {8{16'h0001}}, 0, 1, 0, 1, 3, 0, 0);
    drain();
    // R9 sticky through non-saturating traffic
    send("R9 plain after sat", 128'h1, 128'h1, 0, 0, 0, 0, 0, 0, 0);
    drain();
    check(sat_flag, "R9 sticky", 128'(sat_flag), 128'd1);
    // R10 clear alone
    @(negedge clk); sat_clr = 1'b1;
    @(posedge clk); #1 sat_clr = 1'b0; flag_m = 1'b0;
    @(negedge clk);
    check(!sat_flag, "R10 clear", 128'(sat_flag), 128'd0);
    // R10 clear beats a saturation accepted in the same cycle
    send("R9 set again", 128'hFF, 128'h01, 0, 0, 0, 1, 0, 0, 0);
    drain();
    check(sat_flag, "R9 set", 128'(sat_flag), 128'd1);
    send("R10 clear wins", 128'hFF, 128'h01, 0, 0, 0, 1, 0, 0, 1);
    drain();
    check(!sat_flag, "R10 priority", 128'(sat_flag), 128'd0);

    // R11 back-pressure with mixed traffic (R1 modes and shapes)
    force_rdy = 1'b0;
    for (int n = 0; n < 300; n++) begin
      int sh, esz;
      sh  = $urandom % 4;
      esz = (sh == 0) ? ($urandom % 4) : ($urandom % 3);
      send("R1 mixed", {$urandom, $urandom, $urandom, $urandom},
           {$urandom, $urandom, $urandom, $urandom}, esz, 1'($urandom), 1'($urandom),
           $urandom % 4, sh, 1'($urandom), 1'b0);
    end
    force_rdy = 1'b1;
    drain();
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule